// File: doc/BRIEF.md
# Serial Management Frame Master

This block is the master end of a two-wire management bus: a clock (MDC) and a bidirectional data line. It runs one access to an 8-bit register per request. The frame follows the usual management-bus shape, with a preamble, a start pattern, an opcode, two address fields, a turnaround and a 16-bit data phase. The difference is in how the fields are used. The opcode is always zero. The direction of the access sits in the top bit of the first address field. The 8-bit register number is split, with its high three bits in the first address field and its low five bits in the second.

A host pulses `start` for one cycle and presents the direction flag, the register number and the write byte at the same time. The block shifts the 64-bit frame out MSB first. MDC comes from the system clock through a parameterised divider. On a read, the block releases the data line at the turnaround and takes in the slave's bits. When the frame ends, it pulses `done`. The pad is split into an output value, an output enable and an input.

Top module: `smi_master`

## Requirements
- R1: Every frame begins with 32 bits of 1 followed by a 0 and then a 1 (frame bits 0 to 33, counted in transmit order).
- R2: The two opcode bits that follow the start pattern are 0 and 0 for both reads and writes.
- R3: The next 5-bit field is sent MSB first. Its bit 4 is 1 for a read and 0 for a write, its bit 3 is 0, and its bits 2..0 equal `reg_addr[7:5]`.
- R4: The next 5-bit field is sent MSB first and equals `reg_addr[4:0]`.
- R5: On a write, the turnaround is driven as 1 then 0. The 16-bit data phase that follows is driven MSB first, with the upper 8 bits as 0 and the lower 8 bits equal to `wr_data`.
- R6: On a read, `mdio_oe` is low from the first turnaround bit to the end of the frame. The block samples `mdio_i` on each rising MDC edge of the 16 data bits, MSB first, and the lower 8 of those bits become `rd_data`.
- R7: While no frame is in progress, `mdio_oe` is 0 and `mdc` is 0.
- R8: Each MDC half period lasts CLK_DIV system clocks, and a frame has exactly 64 rising MDC edges. During a frame, `mdio_o` changes only in the cycle where `mdc` falls.
- R9: `busy` is high for exactly 128*CLK_DIV cycles, starting the cycle after `start` is accepted. A `start` that arrives while `busy` is high is ignored: the current frame is unchanged and no second frame follows.
- R10: `done` is high for exactly one cycle, in the first cycle where `busy` is low again.
- R11: `rd_data` changes only when `done` is high at the end of a read. After a write, or between frames, it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a frame |
| rd_nwr | input | 1 | 1 = read, 0 = write; sampled with start |
| reg_addr | input | 8 | Register number; sampled with start |
| wr_data | input | 8 | Write byte; sampled with start |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte from the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench uses a behavioural slave that records every bit of each frame on rising MDC, and compares the frame field by field. Register numbers 0x00 and 0xFF and a random mix drive the split address fields, so a missing bit or a misplaced bit between the two address fields shows up. Read values 0x00, 0xFF, 0xA5 and random bytes show whether the captured bits are ordered or offset wrongly. Write-after-read sequences tell a held `rd_data` from one that a write overwrites, and a start pulse in the middle of a frame shows whether a busy frame can be disturbed.

// File: rtl/smi_master.sv
module smi_master #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rd_nwr,
  input  logic [7:0] reg_addr,
  input  logic [7:0] wr_data,
  output logic       busy,
  output logic       done,
  output logic [7:0] rd_data,
  output logic       mdc,
  output logic       mdio_o,
  output logic       mdio_oe,
  input  logic       mdio_i
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int FRAME_BITS = 64;
  localparam int TA_POS = 46;
  localparam int DATA_POS = 48;

  logic [DW-1:0] div;
  logic [6:0]    cnt;
  logic [63:0]   frame;
  logic [15:0]   rx;
  logic          is_rd;

  wire       tick = (div == DW'(CLK_DIV - 1));
  wire [1:0] ta   = rd_nwr ? 2'b00 : 2'b10;
  wire [7:0] wlo  = rd_nwr ? 8'h00 : wr_data;
  wire [63:0] build = {32'hFFFF_FFFF, 2'b01, 2'b00, rd_nwr, 1'b0,
                       reg_addr[7:5], reg_addr[4:0], ta, 8'h00, wlo};

  assign mdio_o  = frame[63];
  assign mdio_oe = busy && !(is_rd && cnt >= 7'(TA_POS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      rd_data <= '0;
      mdc     <= 1'b0;
      div     <= '0;
      cnt     <= '0;
      frame   <= '0;
      rx      <= '0;
      is_rd   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          frame <= build;
          is_rd <= rd_nwr;
          cnt   <= '0;
          div   <= '0;
          mdc   <= 1'b0;
        end
      end else if (tick) begin
        div <= '0;
        mdc <= ~mdc;
        if (!mdc) begin
          if (cnt >= 7'(DATA_POS)) rx <= {rx[14:0], mdio_i};
        end else if (cnt == 7'(FRAME_BITS - 1)) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          frame <= '0;
          if (is_rd) rd_data <= rx[7:0];
        end else begin
          cnt   <= cnt + 7'd1;
          frame <= {frame[62:0], 1'b0};
        end
      end else begin
        div <= div + DW'(1);
      end
    end
  end
endmodule

module smi_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic [7:0] rd_data,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe
);
  // R7
  idle_oe_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mdio_oe);
  // R7
  idle_mdc_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mdc);
  // R8
  mdo_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy)));
  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(rd_data) |-> done);
endmodule

bind smi_master smi_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rd_data(rd_data),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/smi_master_tb.sv
module smi_master_tb;
  localparam int DIV = 2;
  localparam int FRAME_CYC = 128 * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rd_nwr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] wr_data = '0;
  logic mdio_i = 1'b1;
  logic busy, done, mdc, mdio_o, mdio_oe;
  logic [7:0] rd_data;

  int checks = 0;
  int fails = 0;

  smi_master #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
    .reg_addr(reg_addr), .wr_data(wr_data), .busy(busy), .done(done),
    .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  always #2 clk = ~clk;

  logic [63:0] cap, capoe;
  int k = 0;
  logic slv_rd = 1'b0;
  logic [7:0] slv_val = '0;

  always @(posedge mdc) begin
    if (k < 64) begin
      cap[63-k]   = mdio_o;
      capoe[63-k] = mdio_oe;
    end
    k = k + 1;
  end

  always @(negedge mdc) begin
    if (slv_rd && k == 47) mdio_i = 1'b0;
    else if (slv_rd && k >= 48 && k <= 63) mdio_i = (k >= 56) ? slv_val[63-k] : 1'b0;
    else mdio_i = 1'b1;
  end

  function automatic logic [63:0] exp_frame(logic rd, logic [7:0] a, logic [7:0] d);
    return {32'hFFFF_FFFF, 2'b01, 2'b00, rd, 1'b0, a[7:5], a[4:0],
            rd ? 2'b00 : 2'b10, 8'h00, rd ? 8'h00 : d};
  endfunction

  function automatic logic [63:0] exp_oe(logic rd);
    return rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic rd, input logic [7:0] a, input logic [7:0] d,
                      input logic [7:0] v, input bit poke);
    logic [7:0] prev;
    logic [63:0] ef, eo;
    int bc;
    @(negedge clk);
    slv_rd = rd; slv_val = v; k = 0;
    rd_nwr = rd; reg_addr = a; wr_data = d; start = 1'b1;
    prev = rd_data;
    @(negedge clk);
    start = 1'b0;
    bc = 0;
    while (!done) begin
      if (busy) bc++;
      if (poke && bc == FRAME_CYC / 2) begin
        start = 1'b1; rd_nwr = ~rd; reg_addr = ~a; wr_data = ~d;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    ef = exp_frame(rd, a, d);
    eo = exp_oe(rd);
    check(bc == FRAME_CYC, "R9", "busy cycles", 64'(bc), 64'(FRAME_CYC));
    check(k == 64, "R8", "mdc rising edges", 64'(k), 64'd64);
    check(cap[63:30] == ef[63:30], "R1", "preamble/start", {30'b0, cap[63:30]}, {30'b0, ef[63:30]});
    check(cap[29:28] == 2'b00, "R2", "opcode", {62'b0, cap[29:28]}, 64'd0);
    check(cap[27:23] == ef[27:23], "R3", "phy field", {59'b0, cap[27:23]}, {59'b0, ef[27:23]});
    check(cap[22:18] == ef[22:18], "R4", "reg field", {59'b0, cap[22:18]}, {59'b0, ef[22:18]});
    if (rd) begin
      check(capoe == eo, "R6", "read oe pattern", capoe, eo);
      check(rd_data == v, "R6", "read data", {56'b0, rd_data}, {56'b0, v});
    end else begin
      check(capoe == eo, "R5", "write oe pattern", capoe, eo);
      check(cap[17:0] == ef[17:0], "R5", "ta/data", {46'b0, cap[17:0]}, {46'b0, ef[17:0]});
      check(rd_data == prev, "R11", "rd_data held on write", {56'b0, rd_data}, {56'b0, prev});
    end
    check(!busy, "R10", "busy low at done", {63'b0, busy}, 64'd0);
    @(negedge clk);
    check(!done, "R10", "done one cycle", {63'b0, done}, 64'd0);
    repeat (4 * DIV) @(negedge clk);
    check(!busy && !mdio_oe && !mdc, "R7", "idle after frame",
          {61'b0, busy, mdio_oe, mdc}, 64'd0);
    if (poke) check(k == 64, "R9", "no second frame", 64'(k), 64'd64);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!busy && !done && !mdc && !mdio_oe && rd_data == 8'h00, "R7", "reset state",
          {52'b0, busy, done, mdc, mdio_oe, rd_data}, 64'd0);
    rst_n = 1'b1;
    xfer(1'b1, 8'hFF, 8'h00, 8'hA5, 1'b0);
    xfer(1'b0, 8'hA0, 8'h3C, 8'h00, 1'b0);
    xfer(1'b1, 8'h00, 8'h00, 8'hFF, 1'b0);
    xfer(1'b0, 8'h1F, 8'hFF, 8'h00, 1'b0);
    xfer(1'b1, 8'h5A, 8'h00, 8'h00, 1'b0);
    xfer(1'b0, 8'hE3, 8'h81, 8'h00, 1'b1);
    xfer(1'b1, 8'h27, 8'h00, 8'h96, 1'b1);
    for (int i = 0; i < 16; i++) begin
      xfer(1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 1'b0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule